// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a flash controller. It decides whether an embedded program or erase inside the flash has finished. It does this by reading the status byte repeatedly and checking whether a toggle bit changes between back-to-back reads. A start pulse begins a session. The block then raises a read request, and a separate bus engine serves it. The engine answers each read with a one-cycle completion strobe and the captured byte. The poller groups the reads into pairs and compares the toggle bit of the two reads in each pair.

A pair whose toggle bit matches means the operation has finished. A pair that still toggles while the time-limit flag is low leads to another pair. A pair that toggles with the time-limit flag high triggers exactly one confirming pair, because toggling can stop at the same moment the flag rises. If the confirming pair still toggles, the block reports failure and asks the surrounding logic to issue the flash reset command. An optional pair budget turns an endless toggle into a failure.

Top module: `tgl_poll_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, rd_req_o, done_o, fail_o and rst_cmd_o are all low.
- R2: A start_i pulse while rd_req_o is low raises rd_req_o in the next cycle. rd_req_o stays high until a read has completed. A start_i seen while a session runs is ignored and does not restart the pair budget.
- R3: When the two reads of a pair carry the same value in bit 6 of rd_data_i, done_o is high for the single cycle after the second read's rd_done_i, and rd_req_o is low in that cycle.
- R4: When bit 6 differs within a pair and bit 5 of the pair's second read is low, another pair follows, and neither done_o nor fail_o pulses.
- R5: When bit 6 differs and bit 5 of the second read is high, one confirming pair follows. If that confirming pair does not toggle, done_o pulses.
- R6: When the confirming pair still toggles (whatever bit 5 shows), fail_o and rst_cmd_o pulse together for one cycle.
- R7: done_o and fail_o are never high together. Each is a one-cycle pulse. In a pulse cycle rd_req_o is low and the block is idle.
- R8: With MAX_PAIRS nonzero, if the MAX_PAIRS-th pair of a session toggles and would lead to a further pair, fail_o and rst_cmd_o pulse instead. MAX_PAIRS of zero disables the budget.
- R9: rd_done_i while no read is requested has no effect: no pulse appears, rd_req_o stays low, and the next session behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a polling session when idle |
| rd_req_o | output | 1 | Read request, held until rd_done_i |
| rd_data_i | input | DATA_W | Status byte returned by the read |
| rd_done_i | input | 1 | One-cycle read completion strobe |
| rst_cmd_o | output | 1 | Request to issue the flash reset command |
| done_o | output | 1 | Operation finished successfully (pulse) |
| fail_o | output | 1 | Operation failed (pulse) |

## Verification
A wrong stored first-read bit or a wrong confirm flag shows up at the latest on the second read of the affected pair. It appears as a done_o or fail_o pulse in the wrong cycle, or as a missing pulse while rd_req_o stays high. A miscounted pair budget shows at the MAX_PAIRS-th pair of a toggling session: the failure comes too early, too late, or never. This is most visible when a stray start_i arrives mid-session. A stray read strobe while idle would show as rd_req_o rising or a pulse appearing without a start.

// File: rtl/tgl_poll_pkg.sv
package tgl_poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } poll_state_t;

    typedef struct packed {
        logic toggled;
        logic timeout;
    } pair_view_t;

    typedef enum logic [1:0] {
        ACT_REPEAT  = 2'd0,
        ACT_CONFIRM = 2'd1,
        ACT_PASS    = 2'd2,
        ACT_FAIL    = 2'd3
    } pair_act_t;

    // Verdict on a finished read pair.
    function automatic pair_act_t judge_pair(pair_view_t v, logic confirming,
                                             logic last_allowed);
        if (!v.toggled)       return ACT_PASS;
        else if (confirming)  return ACT_FAIL;
        else if (last_allowed) return ACT_FAIL;
        else if (v.timeout)   return ACT_CONFIRM;
        else                  return ACT_REPEAT;
    endfunction

endpackage

// File: rtl/tgl_pair_cmp.sv
module tgl_pair_cmp
    import tgl_poll_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int TOG_IDX = 6,
    parameter int LIM_IDX = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grab_first,
    input  logic [DATA_W-1:0] rd_data,
    output pair_view_t        view
);
    logic first_q;

    always_ff @(posedge clk) begin
        if (rst)             first_q <= 1'b0;
        else if (grab_first) first_q <= rd_data[TOG_IDX];
    end

    always_comb begin
        view.toggled = first_q ^ rd_data[TOG_IDX];
        view.timeout = rd_data[LIM_IDX];
    end
endmodule

// File: rtl/tgl_pair_budget.sv
module tgl_pair_budget #(
    parameter int unsigned MAX_PAIRS = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic last_pair
);
    localparam int CNT_W = (MAX_PAIRS < 2) ? 1 : $clog2(MAX_PAIRS);

    generate
        if (MAX_PAIRS == 0) begin : g_off
            assign last_pair = 1'b0;
        end else begin : g_on
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst || clear) cnt_q <= '0;
                else if (step)    cnt_q <= cnt_q + 1'b1;
            end
            assign last_pair = (cnt_q == CNT_W'(MAX_PAIRS - 1));
        end
    endgenerate
endmodule

// File: rtl/tgl_poll_ctrl.sv
module tgl_poll_ctrl
    import tgl_poll_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          TOG_IDX   = 6,
    parameter int          LIM_IDX   = 5,
    parameter int unsigned MAX_PAIRS = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              rd_req_o,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              rd_done_i,
    output logic              rst_cmd_o,
    output logic              done_o,
    output logic              fail_o
);
    poll_state_t state_q;
    logic        confirm_q;
    logic        done_q;
    logic        fail_q;
    pair_view_t  view;
    logic        last_pair;
    pair_act_t   act;

    logic accept_start;
    logic first_ack;
    logic second_ack;

    assign accept_start = (state_q == ST_IDLE)   && start_i;
    assign first_ack    = (state_q == ST_FIRST)  && rd_done_i;
    assign second_ack   = (state_q == ST_SECOND) && rd_done_i;

    tgl_pair_cmp #(
        .DATA_W  (DATA_W),
        .TOG_IDX (TOG_IDX),
        .LIM_IDX (LIM_IDX)
    ) i_cmp (
        .clk        (clk),
        .rst        (rst),
        .grab_first (first_ack),
        .rd_data    (rd_data_i),
        .view       (view)
    );

    tgl_pair_budget #(
        .MAX_PAIRS (MAX_PAIRS)
    ) i_budget (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept_start),
        .step      (second_ack),
        .last_pair (last_pair)
    );

    always_comb act = judge_pair(view, confirm_q, last_pair);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            confirm_q <= 1'b0;
            done_q    <= 1'b0;
            fail_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q   <= ST_FIRST;
                        confirm_q <= 1'b0;
                    end
                end
                ST_FIRST: begin
                    if (rd_done_i) state_q <= ST_SECOND;
                end
                ST_SECOND: begin
                    if (rd_done_i) begin
                        unique case (act)
                            ACT_REPEAT:  state_q <= ST_FIRST;
                            ACT_CONFIRM: begin
                                state_q   <= ST_FIRST;
                                confirm_q <= 1'b1;
                            end
                            ACT_PASS: begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end
                            ACT_FAIL: begin
                                state_q <= ST_IDLE;
                                fail_q  <= 1'b1;
                            end
                        endcase
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_req_o  = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign fail_o    = fail_q;
    assign rst_cmd_o = fail_q;
endmodule

// File: rtl/tgl_poll_ctrl_chk.sv
module tgl_poll_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic rd_done_i,
    input logic rd_req_o,
    input logic done_o,
    input logic fail_o,
    input logic rst_cmd_o
);
    // R7
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && fail_o));

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o || fail_o) |=> !(done_o || fail_o));

    // R7
    idle_on_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o || fail_o || rst_cmd_o) |-> !rd_req_o);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_done_i) |=> rd_req_o);

    // R2
    start_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_req_o && start_i) |=> rd_req_o);

    // R3
    outcome_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o || fail_o) |-> $past(rd_done_i && rd_req_o));
endmodule

bind tgl_poll_ctrl tgl_poll_ctrl_chk i_chk (.*);

// File: tb/test_tgl_poll_ctrl.sv
module test_tgl_poll_ctrl;
    localparam int MAXP = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       rd_req_o;
    logic [7:0] rd_data_i = 8'h00;
    logic       rd_done_i = 1'b0;
    logic       rst_cmd_o;
    logic       done_o;
    logic       fail_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int plan_q[$];

    always #10 clk = ~clk;

    tgl_poll_ctrl #(.MAX_PAIRS(MAXP)) i_tgl_poll_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .rd_req_o(rd_req_o),
        .rd_data_i(rd_data_i), .rd_done_i(rd_done_i), .rst_cmd_o(rst_cmd_o),
        .done_o(done_o), .fail_o(fail_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // 0 repeat, 1 confirm, 2 pass, 3 fail
    function automatic int expect_act(bit tog, bit lim, bit conf, bit last);
        if (!tog) return 2;
        if (conf || last) return 3;
        return lim ? 1 : 0;
    endfunction

    task automatic do_read(input logic [7:0] b, input bit poke);
        int w = $urandom_range(0, 3);
        for (int k = 0; k < w; k++) begin
            if (poke && k == 0) start_i = 1'b1;
            @(posedge clk); @(negedge clk);
            start_i = 1'b0;
            chk("R2", "rd_req held", rd_req_o, 1);
        end
        if (poke && w == 0) start_i = 1'b1;
        rd_data_i = b; rd_done_i = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_done_i = 1'b0; start_i = 1'b0;
        rd_data_i = 8'($urandom);
    endtask

    // Codes per pair: 0 no toggle, 1 toggle bit5 low, 2 toggle bit5 high.
    task automatic session(input bit rnd, input int poke_pair);
        bit conf = 0;
        int a;
        start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        chk("R2", "rd_req after start", rd_req_o, 1);
        for (int p = 0; p < 64; p++) begin
            int code;
            logic [7:0] b1, b2;
            if (plan_q.size() > 0) code = plan_q.pop_front();
            else if (rnd) code = $urandom_range(0, 9) < 4 ? 0 : ($urandom_range(0, 3) == 0 ? 2 : 1);
            else code = 0;
            b1 = 8'($urandom);
            b2 = 8'($urandom);
            b2[6] = b1[6] ^ (code != 0);
            b2[5] = (code == 2);
            do_read(b1, p == poke_pair);
            chk("R4", "no pulse mid pair", done_o | fail_o, 0);
            do_read(b2, 1'b0);
            a = expect_act(code != 0, code == 2, conf, (p + 1) == MAXP);
            chk(a == 2 ? "R3" : (a == 3 ? "R6" : "R4"), "done_o", done_o, a == 2);
            chk(a == 3 ? (conf ? "R6" : "R8") : "R5", "fail_o", fail_o, a == 3);
            chk("R6", "rst_cmd_o", rst_cmd_o, a == 3);
            chk("R7", "rd_req after pair", rd_req_o, a < 2);
            if (a == 1) conf = 1;
            if (a >= 2) begin
                @(negedge clk);
                chk("R7", "pulse width", done_o | fail_o | rst_cmd_o, 0);
                chk("R7", "idle after outcome", rd_req_o, 0);
                return;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "rd_req in reset", rd_req_o, 0);
        chk("R1", "pulses in reset", done_o | fail_o | rst_cmd_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "rd_req after reset", rd_req_o, 0);
        chk("R1", "pulses after reset", done_o | fail_o | rst_cmd_o, 0);

        // R9: stray strobe while idle
        rd_data_i = 8'h40; rd_done_i = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_done_i = 1'b0;
        chk("R9", "rd_req after stray strobe", rd_req_o, 0);
        chk("R9", "pulse after stray strobe", done_o | fail_o, 0);

        plan_q = '{0};             session(0, -1);   // R3
        plan_q = '{1, 1, 0};       session(0, -1);   // R4
        plan_q = '{2, 0};          session(0, -1);   // R5
        plan_q = '{2, 1};          session(0, -1);   // R6
        plan_q = '{1, 2, 2};       session(0, -1);   // R6
        plan_q = '{1, 1, 1, 1, 1, 1}; session(0, 3); // R8 with mid-session start (R2)
        plan_q = '{1, 1, 1, 1, 1, 2}; session(0, -1); // R8 at last pair
        for (int s = 0; s < 60; s++) session(1, -1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        process::self(); 
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial void'($urandom(32'd1234));
endmodule